// File: doc/BRIEF.md
# Register-request to per-channel settings bridge

This block sits between a single register-request port and a group of identical signal-processing channels. Each request is a write or a read of one 32-bit word, qualified by a byte address, and carries an optional 64-bit timestamp with a flag that marks it as timed. The bridge splits the byte address into a channel number, a register slot and a half-word select.

On a write, it raises a one-cycle strobe on the addressed channel only. The same channel's settings outputs then carry the slot index, the data, the timestamp and the timed flag. On a read, it picks the addressed channel's 64-bit readback word and returns the selected 32-bit half.

Every request is acknowledged exactly one cycle later. Each channel owns a small readback table of build-time constants. The table holds a compatibility number, the number of half-band stages and the largest CIC interpolation factor. A fixed marker word fills every other slot.

Top module: `ctl_to_setbus`

## Requirements
- R1: The byte address splits into fields. Bits [19:11] give the channel, bits [10:3] give the register slot (0..255), bit 2 selects the half-word, and bits [1:0] are ignored. A write to channel c, slot r drives r on that channel's 8-bit `set_addr` field and the request data on its 32-bit `set_data` field.
- R2: A write to a channel below `NUM_CH` raises that channel's bit of `set_stb` for exactly one cycle, in the cycle after the request. No other channel's strobe rises, and writes on consecutive cycles give strobes on consecutive cycles.
- R3: The request timestamp and timed flag appear, unchanged, on the strobed channel's `set_time` and `set_has_time` fields in the strobe cycle. This holds whether or not the flag is set.
- R4: A channel's address, data, time and timed outputs keep their values in every cycle in which that channel is not strobed.
- R5: A read never raises any strobe and never changes any channel output.
- R6: `resp_ack` is high in exactly the cycle after each request (write, read or both), and low otherwise.
- R7: For a read, address bit 2 selects the half of the 64-bit readback word: 0 returns bits [31:0] and 1 returns bits [63:32].
- R8: Readback slot 0 holds the compatibility word {32'h0, major[15:0], minor[15:0]}. Slot 1 holds the half-band stage count and slot 2 holds the largest CIC interpolation factor, each zero-extended to 64 bits.
- R9: Every other readback slot returns 64'h0BADC0DE0BADC0DE.
- R10: The response data of a write is zero.
- R11: A request whose channel field is at or above `NUM_CH` is still acknowledged. A read of it returns zero; a write of it raises no strobe and changes no channel output.
- R12: A request with both write and read high is handled as a write: one acknowledge, zero response data, and a strobe on the addressed channel.
- R13: While reset is high, the acknowledge, the response data, all strobes and all channel outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write request, one cycle |
| req_rd | input | 1 | Read request, one cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | 32 | Write data |
| req_has_time | input | 1 | Request is timed |
| req_time | input | 64 | Request timestamp |
| resp_ack | output | 1 | Acknowledge, one cycle after the request |
| resp_data | output | 32 | Read data (zero for writes) |
| set_stb | output | NUM_CH | Per-channel settings strobe |
| set_addr | output | NUM_CH*8 | Per-channel register slot, channel i at [8i+7:8i] |
| set_data | output | NUM_CH*32 | Per-channel settings data |
| set_time | output | NUM_CH*64 | Per-channel timestamp |
| set_has_time | output | NUM_CH | Per-channel timed flag |

## Verification
The bound checker watches several properties on every cycle:
- the acknowledge follows each request by one cycle and appears at no other time;
- at most one strobe is high, and only after a write;
- reads and out-of-range writes raise no strobe;
- a write returns zero data;
- an unstrobed channel holds its address and data.

Only the bench scenarios show the content-dependent behaviour. These cover the mapping of address fields onto channels and slots, the readback values of each slot and half, the marker word, and the faithful forwarding of timestamp and flag. They also cover the write-wins rule for combined requests.

// File: rtl/setbus_pkg.sv
package setbus_pkg;

    localparam int SB_ADDR_W  = 8;
    localparam int SB_DATA_W  = 32;
    localparam int SB_TIME_W  = 64;
    localparam int RB_W       = 64;
    localparam int SLOT_LOG2  = 3;
    localparam int HALF_BIT   = 2;
    localparam int CH_SHIFT   = SB_ADDR_W + SLOT_LOG2;

    localparam logic [RB_W-1:0] RB_MARKER = 64'h0BAD_C0DE_0BAD_C0DE;

    localparam logic [SB_ADDR_W-1:0] RB_SLOT_COMPAT = 8'd0;
    localparam logic [SB_ADDR_W-1:0] RB_SLOT_HB     = 8'd1;
    localparam logic [SB_ADDR_W-1:0] RB_SLOT_CIC    = 8'd2;

    typedef struct packed {
        logic                 is_wr;
        logic                 is_rd;
        logic                 in_range;
        logic                 hi_half;
        logic [SB_ADDR_W-1:0] slot;
    } req_dec_t;

    typedef struct packed {
        logic                 stb;
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
        logic [SB_TIME_W-1:0] tstamp;
        logic                 timed;
    } sb_beat_t;

    typedef struct packed {
        logic                 ack;
        logic [SB_DATA_W-1:0] data;
    } resp_t;

endpackage

// File: rtl/setbus_addr_decode.sv
module setbus_addr_decode
    import setbus_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int NUM_CH   = 2,
    parameter int CH_IDX_W = ADDR_W - CH_SHIFT
) (
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    output req_dec_t            dec,
    output logic [CH_IDX_W-1:0] ch_idx
);

    logic unused_low;
    assign unused_low = ^addr[HALF_BIT-1:0];

    always_comb begin
        ch_idx       = addr[ADDR_W-1:CH_SHIFT];
        dec.is_wr    = wr;
        dec.is_rd    = rd & ~wr;
        dec.in_range = ({{(32-CH_IDX_W){1'b0}}, ch_idx} < 32'(NUM_CH));
        dec.slot     = addr[CH_SHIFT-1:SLOT_LOG2];
        dec.hi_half  = addr[HALF_BIT];
    end

endmodule

// File: rtl/setbus_rb_table.sv
module setbus_rb_table
    import setbus_pkg::*;
#(
    parameter logic [15:0] COMPAT_MAJ     = 16'h0000,
    parameter logic [15:0] COMPAT_MIN     = 16'h0000,
    parameter int unsigned HB_STAGES      = 2,
    parameter int unsigned CIC_INTERP_MAX = 128
) (
    input  logic [SB_ADDR_W-1:0] slot,
    output logic [RB_W-1:0]      word
);

    always_comb begin
        case (slot)
            RB_SLOT_COMPAT: word = {32'h0, COMPAT_MAJ, COMPAT_MIN};
            RB_SLOT_HB:     word = 64'(HB_STAGES);
            RB_SLOT_CIC:    word = 64'(CIC_INTERP_MAX);
            default:        word = RB_MARKER;
        endcase
    end

endmodule

// File: rtl/setbus_chan_reg.sv
module setbus_chan_reg
    import setbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic [SB_ADDR_W-1:0] slot,
    input  logic [SB_DATA_W-1:0] data,
    input  logic [SB_TIME_W-1:0] tstamp,
    input  logic                 timed,
    output sb_beat_t             beat
);

    sb_beat_t beat_d, beat_q;

    always_comb begin
        beat_d     = beat_q;
        beat_d.stb = 1'b0;
        if (hit) begin
            beat_d.stb    = 1'b1;
            beat_d.addr   = slot;
            beat_d.data   = data;
            beat_d.tstamp = tstamp;
            beat_d.timed  = timed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign beat = beat_q;

endmodule

// File: rtl/ctl_to_setbus.sv
module ctl_to_setbus
    import setbus_pkg::*;
#(
    parameter int          NUM_CH         = 2,
    parameter int          ADDR_W         = 20,
    parameter logic [15:0] COMPAT_MAJ     = 16'h0000,
    parameter logic [15:0] COMPAT_MIN     = 16'h0000,
    parameter int unsigned HB_STAGES      = 2,
    parameter int unsigned CIC_INTERP_MAX = 128
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_wr,
    input  logic                           req_rd,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [SB_DATA_W-1:0]           req_data,
    input  logic                           req_has_time,
    input  logic [SB_TIME_W-1:0]           req_time,
    output logic                           resp_ack,
    output logic [SB_DATA_W-1:0]           resp_data,
    output logic [NUM_CH-1:0]              set_stb,
    output logic [NUM_CH*SB_ADDR_W-1:0]    set_addr,
    output logic [NUM_CH*SB_DATA_W-1:0]    set_data,
    output logic [NUM_CH*SB_TIME_W-1:0]    set_time,
    output logic [NUM_CH-1:0]              set_has_time
);

    localparam int CH_IDX_W = ADDR_W - CH_SHIFT;

    req_dec_t            dec;
    logic [CH_IDX_W-1:0] ch_idx;
    logic [RB_W-1:0]     rb_word [NUM_CH];
    logic [RB_W-1:0]     rb_sel;
    resp_t               resp_d, resp_q;

    setbus_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .CH_IDX_W (CH_IDX_W)
    ) u_dec (
        .wr     (req_wr),
        .rd     (req_rd),
        .addr   (req_addr),
        .dec    (dec),
        .ch_idx (ch_idx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sb_beat_t beat;
        logic     hit;

        assign hit = dec.is_wr & dec.in_range & (ch_idx == CH_IDX_W'(i));

        setbus_chan_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit),
            .slot   (dec.slot),
            .data   (req_data),
            .tstamp (req_time),
            .timed  (req_has_time),
            .beat   (beat)
        );

        setbus_rb_table #(
            .COMPAT_MAJ     (COMPAT_MAJ),
            .COMPAT_MIN     (COMPAT_MIN),
            .HB_STAGES      (HB_STAGES),
            .CIC_INTERP_MAX (CIC_INTERP_MAX)
        ) u_rb (
            .slot (dec.slot),
            .word (rb_word[i])
        );

        assign set_stb[i]                           = beat.stb;
        assign set_addr[i*SB_ADDR_W +: SB_ADDR_W]   = beat.addr;
        assign set_data[i*SB_DATA_W +: SB_DATA_W]   = beat.data;
        assign set_time[i*SB_TIME_W +: SB_TIME_W]   = beat.tstamp;
        assign set_has_time[i]                      = beat.timed;
    end

    always_comb begin
        rb_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_IDX_W'(i)) rb_sel = rb_word[i];
        end
    end

    always_comb begin
        resp_d.ack  = dec.is_wr | dec.is_rd;
        resp_d.data = '0;
        if (dec.is_rd && dec.in_range) begin
            resp_d.data = dec.hi_half ? rb_sel[RB_W-1:SB_DATA_W] : rb_sel[SB_DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign resp_ack  = resp_q.ack;
    assign resp_data = resp_q.data;

endmodule

// File: rtl/ctl_to_setbus_chk.sv
module ctl_to_setbus_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 20
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_wr,
    input logic                  req_rd,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  resp_ack,
    input logic [31:0]           resp_data,
    input logic [NUM_CH-1:0]     set_stb,
    input logic [NUM_CH*8-1:0]   set_addr,
    input logic [NUM_CH*32-1:0]  set_data
);

    localparam int CW = ADDR_W - 11;

    logic [CW-1:0] req_ch;
    logic          req_oor;
    assign req_ch  = req_addr[ADDR_W-1:11];
    assign req_oor = ({{(32-CW){1'b0}}, req_ch} >= 32'(NUM_CH));

    // R6
    ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr || req_rd) |=> resp_ack);

    // R6
    ack_only_req_chk: assert property (@(posedge clk) disable iff (rst)
        resp_ack |-> $past(req_wr || req_rd));

    // R2
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_stb));

    // R2
    stb_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_stb) |-> $past(req_wr));

    // R5
    rd_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !req_wr) |=> (set_stb == '0));

    // R11
    oor_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr && req_oor) |=> (set_stb == '0));

    // R10
    wr_resp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_wr |=> (resp_data == 32'h0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hold
        // R4
        hold_data_chk: assert property (@(posedge clk) disable iff (rst)
            !set_stb[i] |-> $stable(set_data[i*32 +: 32]));
        // R4
        hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
            !set_stb[i] |-> $stable(set_addr[i*8 +: 8]));
    end

endmodule

bind ctl_to_setbus ctl_to_setbus_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .resp_ack  (resp_ack),
    .resp_data (resp_data),
    .set_stb   (set_stb),
    .set_addr  (set_addr),
    .set_data  (set_data)
);

// File: tb/ctl_to_setbus_bench.sv
`timescale 1ns/1ps
module ctl_to_setbus_bench;

    localparam int          NCH = 4;
    localparam logic [15:0] MAJ = 16'h0002;
    localparam logic [15:0] MIN = 16'h0007;
    localparam int          HB  = 3;
    localparam int          CIC = 128;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_wr = 1'b0, req_rd = 1'b0, req_has_time = 1'b0;
    logic [19:0]         req_addr = '0;
    logic [31:0]         req_data = '0;
    logic [63:0]         req_time = '0;
    logic                resp_ack;
    logic [31:0]         resp_data;
    logic [NCH-1:0]      set_stb, set_has_time;
    logic [NCH*8-1:0]    set_addr;
    logic [NCH*32-1:0]   set_data;
    logic [NCH*64-1:0]   set_time;

    always #2 clk = ~clk;

    ctl_to_setbus #(
        .NUM_CH (NCH), .ADDR_W (20), .COMPAT_MAJ (MAJ), .COMPAT_MIN (MIN),
        .HB_STAGES (HB), .CIC_INTERP_MAX (CIC)
    ) u_ctl_to_setbus (
        .clk (clk), .rst (rst), .req_wr (req_wr), .req_rd (req_rd),
        .req_addr (req_addr), .req_data (req_data), .req_has_time (req_has_time),
        .req_time (req_time), .resp_ack (resp_ack), .resp_data (resp_data),
        .set_stb (set_stb), .set_addr (set_addr), .set_data (set_data),
        .set_time (set_time), .set_has_time (set_has_time)
    );

    typedef struct {
        string             tag;
        logic [31:0]       data;
        logic [NCH-1:0]    stb;
        logic [NCH*8-1:0]  a;
        logic [NCH*32-1:0] d;
        logic [NCH*64-1:0] t;
        logic [NCH-1:0]    h;
    } exp_t;

    exp_t              sbq[$];
    logic [NCH*8-1:0]  m_a = '0;
    logic [NCH*32-1:0] m_d = '0;
    logic [NCH*64-1:0] m_t = '0;
    logic [NCH-1:0]    m_h = '0;
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rb_of(int idx);
        case (idx)
            0:       rb_of = {32'h0, MAJ, MIN};
            1:       rb_of = 64'(HB);
            2:       rb_of = 64'(CIC);
            default: rb_of = 64'h0BAD_C0DE_0BAD_C0DE;
        endcase
    endfunction

    function automatic logic [19:0] mk(int ch, int idx, bit hi);
        mk = {ch[8:0], idx[7:0], hi, 2'b00};
    endfunction

    task automatic do_req(bit wr, bit rd, logic [19:0] addr, logic [31:0] data,
                          bit ht, logic [63:0] tm, string tag);
        exp_t        e;
        int          ch;
        logic [63:0] w;
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = addr; req_data = data;
        req_has_time = ht; req_time = tm;
        ch = int'(addr[19:11]);
        e.stb = '0;
        e.data = '0;
        if (wr) begin
            if (ch < NCH) begin
                e.stb[ch] = 1'b1;
                m_a[ch*8 +: 8] = addr[10:3];
                m_d[ch*32 +: 32] = data;
                m_t[ch*64 +: 64] = tm;
                m_h[ch] = ht;
            end
        end else if (rd && ch < NCH) begin
            w = rb_of(int'(addr[10:3]));
            e.data = addr[2] ? w[63:32] : w[31:0];
        end
        e.tag = tag; e.a = m_a; e.d = m_d; e.t = m_t; e.h = m_h;
        sbq.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            req_wr = 1'b0; req_rd = 1'b0; req_has_time = 1'b0;
            req_addr = '0; req_data = '0; req_time = '0;
        end
    endtask

    task automatic one(bit wr, bit rd, logic [19:0] addr, logic [31:0] data,
                       bit ht, logic [63:0] tm, string tag);
        do_req(wr, rd, addr, data, ht, tm, tag);
        idle(1);
    endtask

    // Monitor: one expected item is due in the cycle after each request
    initial begin
        exp_t e;
        @(negedge rst);
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(resp_ack === 1'b1, e.tag, "R6 ack", 256'(resp_ack), 256'(1));
                chk(resp_data === e.data, e.tag, "resp_data", 256'(resp_data), 256'(e.data));
                chk(set_stb === e.stb, e.tag, "R2 set_stb", 256'(set_stb), 256'(e.stb));
                chk(set_addr === e.a, e.tag, "R1 set_addr", 256'(set_addr), 256'(e.a));
                chk(set_data === e.d, e.tag, "R1 R4 set_data", 256'(set_data), 256'(e.d));
                chk(set_time === e.t && set_has_time === e.h, e.tag, "R3 time/flag",
                    256'(set_time), 256'(e.t));
            end else begin
                chk(resp_ack === 1'b0 && set_stb === '0, "R6", "idle ack/stb",
                    256'({resp_ack, set_stb}), 256'(0));
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R13: outputs during reset
        chk(resp_ack === 1'b0 && resp_data === '0, "R13", "resp in reset",
            256'({resp_ack, resp_data}), 256'(0));
        chk(set_stb === '0 && set_has_time === '0 && set_addr === '0 &&
            set_data === '0 && set_time === '0, "R13", "channels in reset",
            256'(set_data), 256'(0));
        rst = 1'b0;

        one(1, 0, mk(0, 5, 0), 32'hDEAD_0001, 0, 64'h0, "R1 R2 write ch0 slot5");
        one(1, 0, mk(3, 200, 0), 32'hCAFE_0003, 1, 64'h0123_4567_89AB_CDEF, "R3 timed write ch3");
        one(1, 0, mk(1, 0, 1), 32'h1111_2222, 0, 64'hFFFF_0000_FFFF_0000, "R3 untimed write ch1");
        do_req(1, 0, mk(2, 17, 0), 32'hAAAA_5555, 1, 64'h5, "R2 back-to-back ch2");
        do_req(1, 0, mk(1, 99, 0), 32'h5555_AAAA, 0, 64'h6, "R2 back-to-back ch1");
        idle(2);

        one(0, 1, mk(0, 0, 0), '0, 0, '0, "R8 R7 read slot0 low");
        one(0, 1, mk(0, 0, 1), '0, 0, '0, "R8 R7 read slot0 high");
        one(0, 1, mk(2, 1, 0), '0, 0, '0, "R8 R5 read slot1 ch2");
        one(0, 1, mk(3, 2, 0), '0, 0, '0, "R8 read slot2 low");
        one(0, 1, mk(3, 2, 1), '0, 0, '0, "R8 R7 read slot2 high");
        one(0, 1, mk(1, 9, 0), '0, 0, '0, "R9 marker low");
        one(0, 1, mk(1, 9, 1), '0, 0, '0, "R9 marker high");
        one(0, 1, mk(0, 255, 1) | 20'h3, '0, 0, '0, "R9 R1 slot255 low bits set");

        one(1, 0, mk(4, 3, 0), 32'hBBBB_0004, 1, 64'h77, "R11 write ch4");
        one(1, 0, mk(511, 3, 0), 32'hBBBB_01FF, 0, 64'h78, "R11 write ch511");
        one(0, 1, mk(4, 0, 0), '0, 0, '0, "R11 read ch4");
        one(1, 1, mk(1, 2, 1), 32'h0C0C_0C0C, 1, 64'h99, "R12 write and read together");
        one(1, 0, mk(0, 6, 0), 32'h0000_0000, 0, 64'h0, "R10 write zero response");

        idle(6);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule